// File: doc/BRIEF.md
# Looped-Flag Synchronous FIFO Queue

This block is a single-clock first-in-first-out queue held in a register array. A head index marks where the next word is written. A tail index marks the word that the next read returns. A one-bit looped flag tells the two cases apart when the indexes are equal: if the flag is clear the queue is empty, and if it is set the queue is full. The flag turns on when the head wraps from the last entry back to entry 0. It turns off when the tail makes the same wrap.

Producers and consumers share one rising clock edge. A write is accepted while the queue is not full. A read is accepted while it is not empty. A request that fails its condition is dropped, and nothing inside changes. Read data comes from a register that holds its value between accepted reads. Five status outputs report the fill level: full, empty, half-full, and two thresholds (almost-full and almost-empty) set by parameters. The default size is 16 words of 4 bits. The intended range is up to 256 words of up to 8 bits.

Top module: `loopq_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is empty=1, full=0, half_full=0, almost_full=0, almost_empty=1, and rd_data all zeros.
- R2: Accepted words come out in the order they were written. Each one appears on `rd_data` one cycle after the edge that accepted the read.
- R3: `empty` is 1 exactly when no words are stored. `full` is 1 exactly when DEPTH words are stored. The two are never 1 together.
- R4: A write presented while `full` is 1 is dropped. The fill level stays the same, and the stored words are later read back unchanged.
- R5: A read presented while `empty` is 1 is dropped. `rd_data` and all status flags stay the same.
- R6: A read and a write presented in the same cycle, while the queue is neither full nor empty, are both accepted. The fill level, and therefore every status flag, stays the same.
- R7: A read and a write in the same cycle behave as follows. At full, only the read is accepted, leaving DEPTH-1 words. At empty, only the write is accepted, leaving 1 word.
- R8: `half_full` is 1 exactly when the fill level is at least DEPTH/2.
- R9: `almost_full` is 1 exactly when the fill level is at least AFULL_LVL (default DEPTH-2). `almost_empty` is 1 exactly when the fill level is at most AEMPTY_LVL (default 2).
- R10: `rd_data` keeps its previous value in every cycle that accepts no read.
- R11: Operation stays correct for any number of pointer wraps. The looped flag is set by a head wrap and cleared by a tail wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No words stored |
| half_full | output | 1 | Fill level at least DEPTH/2 |
| almost_full | output | 1 | Fill level at least AFULL_LVL |
| almost_empty | output | 1 | Fill level at most AEMPTY_LVL |

## Verification
A read and a write can fall in the same cycle. The interesting cases are at the two edges of the fill range: at full the write must be dropped while the read goes through, and at empty the reverse must happen. These cases are forced by directed sequences that fill or drain the queue exactly and then raise both enables together. Further cases come from random phases that lean toward heavy writing, heavy reading or a balanced mix, which run the pointers through many wraps. A queue model in the bench decides which request is accepted in each cycle, and then predicts every flag and every read word.

// File: rtl/loopq_pkg.sv
package loopq_pkg;

    // Which requests were accepted in a cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } loopq_op_e;

    // Status flags derived from the fill level
    typedef struct packed {
        logic full;
        logic empty;
        logic half;
        logic afull;
        logic aempty;
    } loopq_flags_t;

    // Threshold-based flags; full/empty are decided from pointers elsewhere
    function automatic loopq_flags_t level_flags(input int unsigned fill,
                                                 input int unsigned depth,
                                                 input int unsigned afull_lvl,
                                                 input int unsigned aempty_lvl);
        loopq_flags_t f;
        f.full   = 1'b0;
        f.empty  = 1'b0;
        f.half   = (fill >= depth / 2);
        f.afull  = (fill >= afull_lvl);
        f.aempty = (fill <= aempty_lvl);
        return f;
    endfunction

    function automatic loopq_op_e encode_op(input logic push, input logic pop);
        return loopq_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/loopq_ptr.sv
module loopq_ptr #(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [AW-1:0] idx,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    assign wrap = advance && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (advance) begin
            idx <= (idx == LAST) ? '0 : idx + AW'(1);
        end
    end
endmodule

// File: rtl/loopq_store.sv
module loopq_store #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/loopq_status.sv
module loopq_status
    import loopq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int AFULL_LVL  = DEPTH - 2,
    parameter int AEMPTY_LVL = 2,
    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] tail,
    input  logic          looped,
    output loopq_flags_t  flags
);
    logic [CW-1:0] fill;
    logic          same;
    loopq_flags_t  lvl;

    always_comb begin
        same = (head == tail);
        if (looped) begin
            fill = CW'(DEPTH) - CW'(tail) + CW'(head);
        end else begin
            fill = CW'(head) - CW'(tail);
        end
        lvl = level_flags(int'(fill), DEPTH, AFULL_LVL, AEMPTY_LVL);
        flags        = lvl;
        flags.full   = same && looped;
        flags.empty  = same && !looped;
    end
endmodule

// File: rtl/loopq_fifo.sv
module loopq_fifo
    import loopq_pkg::*;
#(
    parameter int DATA_W     = 4,
    parameter int DEPTH      = 16,
    parameter int AFULL_LVL  = DEPTH - 2,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              half_full,
    output logic              almost_full,
    output logic              almost_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] head, tail;
    logic          head_wrap, tail_wrap;
    logic          looped;
    loopq_flags_t  flags;
    loopq_op_e     op;
    logic          push, pop;

    // Requests are qualified by the current flags; rejected ones vanish
    assign op   = encode_op(wr_en && !flags.full, rd_en && !flags.empty);
    assign push = (op == OP_PUSH) || (op == OP_BOTH);
    assign pop  = (op == OP_POP)  || (op == OP_BOTH);

    loopq_ptr #(.DEPTH(DEPTH)) u_head (
        .clk     (clk),
        .rst     (rst),
        .advance (push),
        .idx     (head),
        .wrap    (head_wrap)
    );

    loopq_ptr #(.DEPTH(DEPTH)) u_tail (
        .clk     (clk),
        .rst     (rst),
        .advance (pop),
        .idx     (tail),
        .wrap    (tail_wrap)
    );

    // Head wrap sets, tail wrap clears; both together leave it as is
    always_ff @(posedge clk) begin
        if (rst) begin
            looped <= 1'b0;
        end else begin
            looped <= looped ^ head_wrap ^ tail_wrap;
        end
    end

    loopq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (push),
        .waddr (head),
        .wdata (wr_data),
        .re    (pop),
        .raddr (tail),
        .rdata (rd_data)
    );

    loopq_status #(
        .DEPTH      (DEPTH),
        .AFULL_LVL  (AFULL_LVL),
        .AEMPTY_LVL (AEMPTY_LVL)
    ) u_status (
        .head   (head),
        .tail   (tail),
        .looped (looped),
        .flags  (flags)
    );

    assign full         = flags.full;
    assign empty        = flags.empty;
    assign half_full    = flags.half;
    assign almost_full  = flags.afull;
    assign almost_empty = flags.aempty;
endmodule

// File: rtl/loopq_checker.sv
module loopq_checker #(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              empty,
    input logic              half_full,
    input logic              almost_full,
    input logic              almost_empty
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (empty && !full && !half_full && !almost_full && almost_empty && rd_data == '0)); // R1

    AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R3

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> full); // R4

    AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data))); // R5

    AST_BOTH_MID_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!full && !empty && wr_en && rd_en) |=>
            $stable({full, empty, half_full, almost_full, almost_empty})); // R6

    AST_READ_AT_FULL: assert property (@(posedge clk) disable iff (rst)
        (full && rd_en) |=> !full); // R7

    AST_WRITE_AT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (empty && wr_en) |=> !empty); // R7

    AST_FULL_IMPLIES_LEVELS: assert property (@(posedge clk) disable iff (rst)
        full |-> (half_full && almost_full)); // R9

    AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R10
endmodule

bind loopq_fifo loopq_checker #(.DATA_W(DATA_W)) u_loopq_checker (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .full         (full),
    .empty        (empty),
    .half_full    (half_full),
    .almost_full  (almost_full),
    .almost_empty (almost_empty)
);

// File: tb/loopq_fifo_bench.sv
module loopq_fifo_bench;
    localparam int DW    = 4;
    localparam int DEPTH = 16;
    localparam int AF    = DEPTH - 2;
    localparam int AE    = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          full, empty, half_full, almost_full, almost_empty;

    int unsigned   n_checks = 0;
    int unsigned   n_fail   = 0;
    bit            finished = 0;

    logic [DW-1:0] model_q[$];
    logic [DW-1:0] exp_rd;

    always #10 clk = ~clk;

    loopq_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_loopq_fifo (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .full         (full),
        .empty        (empty),
        .half_full    (half_full),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_half(input int n);
        return n >= DEPTH / 2;
    endfunction

    function automatic logic exp_af(input int n);
        return n >= AF;
    endfunction

    function automatic logic exp_ae(input int n);
        return n <= AE;
    endfunction

    // One cycle: drive at negedge, model on posedge, check at next negedge
    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        int    pre;
        logic  wacc, racc;
        string tag_rd, tag_fe;
        wr_en   = w;
        rd_en   = r;
        wr_data = d;
        pre  = model_q.size();
        wacc = w && (pre != DEPTH);
        racc = r && (pre != 0);
        @(posedge clk);
        if (racc) exp_rd = model_q.pop_front();
        if (wacc) model_q.push_back(d);
        @(negedge clk);
        if (racc)      tag_rd = "R2 read order";
        else if (r)    tag_rd = "R5 dropped read holds data";
        else           tag_rd = "R10 data hold";
        if (w && r && (pre == 0 || pre == DEPTH)) tag_fe = "R7 both at boundary";
        else if (w && r)                          tag_fe = "R6 both at mid level";
        else if (w && pre == DEPTH)               tag_fe = "R4 dropped write";
        else if (r && pre == 0)                   tag_fe = "R5 dropped read";
        else                                      tag_fe = "R3 full/empty";
        chk(tag_rd, 32'(rd_data), 32'(exp_rd));
        chk({tag_fe, " full"},  32'(full),  32'(model_q.size() == DEPTH));
        chk({tag_fe, " empty"}, 32'(empty), 32'(model_q.size() == 0));
        chk("R8 half_full", 32'(half_full), 32'(exp_half(model_q.size())));
        chk("R9 almost_full", 32'(almost_full), 32'(exp_af(model_q.size())));
        chk("R9 almost_empty", 32'(almost_empty), 32'(exp_ae(model_q.size())));
    endtask

    initial begin
        int pw, pr;
        void'($urandom(32'd20240611));
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        exp_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 half_full", 32'(half_full), 32'd0);
        chk("R1 almost_full", 32'(almost_full), 32'd0);
        chk("R1 almost_empty", 32'(almost_empty), 32'd1);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        rst = 1'b0;

        // R5: read on empty dropped
        step(1'b0, 1'b1, '0);
        // R7: both at empty -> only write accepted
        step(1'b1, 1'b1, 4'h9);
        // R6: both at mid level
        step(1'b1, 1'b0, 4'h3);
        step(1'b1, 1'b1, 4'h4);
        // Fill to full, then R4: writes while full dropped
        while (model_q.size() < DEPTH) step(1'b1, 1'b0, 4'(model_q.size() + 5));
        step(1'b1, 1'b0, 4'hF);
        step(1'b1, 1'b0, 4'hE);
        // R7: both at full -> only read accepted
        step(1'b1, 1'b1, 4'hA);
        // Drain fully; R4 data unchanged is seen here
        while (model_q.size() > 0) step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        // R11: random phases with many pointer wraps
        for (int ph = 0; ph < 12; ph++) begin
            case (ph % 3)
                0: begin pw = 80; pr = 30; end
                1: begin pw = 30; pr = 80; end
                default: begin pw = 60; pr = 60; end
            endcase
            for (int i = 0; i < 300; i++) begin
                step(($urandom % 100) < pw, ($urandom % 100) < pr, 4'($urandom));
            end
        end
        // Mid-run reset returns to R1 state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        exp_rd = '0;
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        step(1'b1, 1'b0, 4'h6);
        step(1'b0, 1'b1, '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule